// File: doc/BRIEF.md
# Vectored Priority Nesting Unit

This unit sits behind an interrupt router and turns a pending set of sources into a nested service discipline. It holds sixteen programmable vector slots and one default vector. Each slot can bind one of thirty-two sources to a 32-bit handler address. The slot index is the priority, and slot 0 is the most urgent. A seventeenth level, just below the slots, covers every source that no enabled slot claims. A separate idle level (value 17) means that nothing is in service.

The unit drives the normal interrupt request only when an already-masked pending source outranks the level now in service. Software starts a service episode by reading the vector-address register. The read returns the handler address, moves the service level to the claimed priority, and records the old level for that priority. Any write to the same register closes the episode and restores the recorded level, so nested handlers unwind in order. Source routing and enable masking happen upstream. The unit receives both the raw and the masked pending vectors.

Top module: `vector_nest_unit`

## Requirements
- R1: Slot n's handler address is read and written at byte offset 0x100+4n. Slot n's 8-bit control is read and written at 0x200+4n, where bit 5 enables the slot and bits 4:0 name its source. The default address is read and written at 0x034. Only word-aligned addresses are decoded.
- R2: The mask of level L is the OR of the source bits of the enabled slots with index below L. Level 16 covers all slots, and the idle level 17 covers every source. irqReq is high exactly when maskedIrq AND the mask of the current level is nonzero.
- R3: A read of 0x030 qualified by regValid searches for the smallest level i below the current level where rawIrq AND the mask of level i+1 is nonzero. On a hit, it saves the current level for i, makes i current on the next cycle, and returns slot i's address, or the default address when i is 16.
- R4: When that search finds nothing, the level stays unchanged. The read returns the address of the current level's slot, or the default address when the current level is 16 or 17.
- R5: A write to 0x030 qualified by regValid ignores its data. When the current level is below 17, it restores the level saved for the current level. At level 17 it has no effect.
- R6: Nested acknowledges followed by ends unwind the levels in last-in, first-out order.
- R7: The eight words from 0xFE0 to 0xFFC read the identification bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order, in bits 7:0.
- R8: After reset, all slot addresses, slot controls and the default address are zero, and the level is 17.
- R9: With regValid low, placing 0x030 on regAddr changes no level. The address it would claim is still shown on regRdata.
- R10: A slot control write changes irqReq from the next cycle on.
- R11: A slot whose bit 5 is clear adds nothing to any mask. An acknowledge of its source claims level 16 and returns the default address.
- R12: Undecoded addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rawIrq | input | 32 | Pending sources before enable masking |
| maskedIrq | input | 32 | Pending, enabled, normal-class sources |
| regValid | input | 1 | Bus access strobe, already qualified by the handshake |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr and state |
| irqReq | output | 1 | Normal interrupt request |

## Verification
The bench uses several source patterns, and each one separates a different part of the behaviour:
- A single vectored source at idle checks the idle mask against the slot masks.
- A more urgent source arriving while a lower slot is in service checks the strict-priority nesting and the LIFO unwind.
- A source that no enabled slot claims checks the level-16 default path.
- A disabled slot that is later enabled under service checks the next-cycle mask update.
- A pending source of lower priority than the level in service confirms that an acknowledge leaves the level untouched.
- Unqualified reads and end-writes at idle confirm that these accesses leave the level unchanged.

// File: rtl/vnest_pkg.sv
package vnest_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_SLOT_ADDR, SEL_SLOT_CTRL, SEL_VECT, SEL_DEFAULT, SEL_ID
  } regSel_e;

  typedef struct packed {
    logic       wrSlotAddr;
    logic       wrSlotCtrl;
    logic       wrDefault;
    regSel_e    rdSel;
    logic [5:0] slotIdx;
    logic [2:0] idIdx;
  } dpStrobe_t;

  localparam logic [11:0] OFS_VECT      = 12'h030;
  localparam logic [11:0] OFS_DEFAULT   = 12'h034;
  localparam logic [11:0] OFS_SLOT_ADDR = 12'h100;
  localparam logic [11:0] OFS_SLOT_CTRL = 12'h200;
  localparam logic [11:0] OFS_ID        = 12'hFE0;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h90;
      3'd1: idByte = 8'h11;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/vnest_control.sv
module vnest_control
  import vnest_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  localparam int PW       = $clog2(NUM_SLOTS + 2)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            regValid,
  input  logic                            regWrite,
  input  logic [11:0]                     regAddr,
  input  logic [SRC_W-1:0]                rawIrq,
  input  logic [NUM_SLOTS:0][SRC_W-1:0]   upperMask, // upperMask[i] = mask of level i+1
  output dpStrobe_t                       strobe,
  output logic [PW-1:0]                   curPrio,
  output logic [PW-1:0]                   selLevel
);
  localparam logic [PW-1:0] IDLE = PW'(NUM_SLOTS + 1);

  logic          ackRead, endWrite, hitFound;
  logic [PW-1:0] pick;
  logic [PW-1:0] prevPrio [NUM_SLOTS+1];

  // Address decode into datapath strobes
  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    if (regAddr[1:0] == 2'b00) begin
      if (regAddr[11:8] == OFS_SLOT_ADDR[11:8] && {1'b0, regAddr[7:2]} < 7'(NUM_SLOTS)) begin
        strobe.rdSel      = SEL_SLOT_ADDR;
        strobe.slotIdx    = regAddr[7:2];
        strobe.wrSlotAddr = regValid && regWrite;
      end else if (regAddr[11:8] == OFS_SLOT_CTRL[11:8] && {1'b0, regAddr[7:2]} < 7'(NUM_SLOTS)) begin
        strobe.rdSel      = SEL_SLOT_CTRL;
        strobe.slotIdx    = regAddr[7:2];
        strobe.wrSlotCtrl = regValid && regWrite;
      end else if (regAddr == OFS_VECT) begin
        strobe.rdSel = SEL_VECT;
      end else if (regAddr == OFS_DEFAULT) begin
        strobe.rdSel     = SEL_DEFAULT;
        strobe.wrDefault = regValid && regWrite;
      end else if (regAddr[11:5] == OFS_ID[11:5]) begin
        strobe.rdSel = SEL_ID;
        strobe.idIdx = regAddr[4:2];
      end
    end
  end

  assign ackRead  = regValid && !regWrite && strobe.rdSel == SEL_VECT;
  assign endWrite = regValid &&  regWrite && strobe.rdSel == SEL_VECT;

  // Search for the most urgent level above the one in service
  always_comb begin
    hitFound = 1'b0;
    pick     = curPrio;
    for (int i = 0; i <= NUM_SLOTS; i++) begin
      if (!hitFound && PW'(i) < curPrio && |(rawIrq & upperMask[i])) begin
        hitFound = 1'b1;
        pick     = PW'(i);
      end
    end
  end
  assign selLevel = pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPrio <= IDLE;
      for (int i = 0; i <= NUM_SLOTS; i++) prevPrio[i] <= IDLE;
    end else if (ackRead && hitFound) begin
      prevPrio[pick] <= curPrio;
      curPrio        <= pick;
    end else if (endWrite && curPrio != IDLE) begin
      curPrio <= prevPrio[curPrio];
    end
  end

  p_ack_never_lowers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ackRead |=> curPrio <= $past(curPrio));
  p_end_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (endWrite && curPrio != IDLE) |=> curPrio > $past(curPrio));
  p_end_idle_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (endWrite && curPrio == IDLE) |=> curPrio == IDLE);
  p_unqualified_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !regValid |=> $stable(curPrio));
  p_level_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    curPrio <= IDLE);
endmodule

// File: rtl/vnest_datapath.sv
module vnest_datapath
  import vnest_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  parameter int DATA_W    = 32,
  localparam int PW       = $clog2(NUM_SLOTS + 2),
  localparam int SIW      = $clog2(SRC_W),
  localparam int EN_BIT   = SIW
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  dpStrobe_t                         strobe,
  input  logic [DATA_W-1:0]                 regWdata,
  input  logic [SRC_W-1:0]                  maskedIrq,
  input  logic [PW-1:0]                     curPrio,
  input  logic [PW-1:0]                     selLevel,
  output logic [NUM_SLOTS+1:0][SRC_W-1:0]   levelMask,
  output logic [DATA_W-1:0]                 regRdata,
  output logic                              irqReq
);
  logic [DATA_W-1:0] slotAddr [NUM_SLOTS];
  logic [7:0]        slotCtrl [NUM_SLOTS];
  logic [DATA_W-1:0] defAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defAddr <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        slotAddr[s] <= '0;
        slotCtrl[s] <= '0;
      end
    end else begin
      if (strobe.wrDefault) defAddr <= regWdata;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (strobe.wrSlotAddr && strobe.slotIdx == 6'(s)) slotAddr[s] <= regWdata;
        if (strobe.wrSlotCtrl && strobe.slotIdx == 6'(s)) slotCtrl[s] <= regWdata[7:0];
      end
    end
  end

  // Cumulative priority masks, one per level
  always_comb begin
    levelMask[0] = '0;
    for (int l = 0; l < NUM_SLOTS; l++)
      levelMask[l+1] = levelMask[l] |
        (slotCtrl[l][EN_BIT] ? (SRC_W'(1) << slotCtrl[l][SIW-1:0]) : '0);
    levelMask[NUM_SLOTS+1] = '1;
  end

  assign irqReq = |(maskedIrq & levelMask[curPrio]);

  always_comb begin
    regRdata = '0;
    case (strobe.rdSel)
      SEL_SLOT_ADDR:
        for (int s = 0; s < NUM_SLOTS; s++)
          if (strobe.slotIdx == 6'(s)) regRdata = slotAddr[s];
      SEL_SLOT_CTRL:
        for (int s = 0; s < NUM_SLOTS; s++)
          if (strobe.slotIdx == 6'(s)) regRdata = DATA_W'(slotCtrl[s]);
      SEL_VECT: begin
        if (selLevel >= PW'(NUM_SLOTS)) regRdata = defAddr;
        else
          for (int s = 0; s < NUM_SLOTS; s++)
            if (selLevel == PW'(s)) regRdata = slotAddr[s];
      end
      SEL_DEFAULT: regRdata = defAddr;
      SEL_ID:      regRdata = DATA_W'(idByte(strobe.idIdx));
      default:     regRdata = '0;
    endcase
  end

  p_idle_sees_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (curPrio == PW'(NUM_SLOTS + 1)) |-> (irqReq == |maskedIrq));
  p_top_level_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (curPrio == '0) |-> !irqReq);
endmodule

// File: rtl/vector_nest_unit.sv
module vector_nest_unit
  import vnest_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  parameter int DATA_W    = 32,
  localparam int PW       = $clog2(NUM_SLOTS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  rawIrq,
  input  logic [SRC_W-1:0]  maskedIrq,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [11:0]       regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqReq
);
  dpStrobe_t                          strobe;
  logic [PW-1:0]                      curPrio, selLevel;
  logic [NUM_SLOTS+1:0][SRC_W-1:0]    levelMask;

  vnest_control #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .rawIrq(rawIrq), .upperMask(levelMask[NUM_SLOTS+1:1]),
    .strobe(strobe), .curPrio(curPrio), .selLevel(selLevel)
  );

  vnest_datapath #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .regWdata(regWdata),
    .maskedIrq(maskedIrq), .curPrio(curPrio), .selLevel(selLevel),
    .levelMask(levelMask), .regRdata(regRdata), .irqReq(irqReq)
  );
endmodule

// File: tb/vector_nest_unit_tb.sv
module vector_nest_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rawIrq = '0, maskedIrq = '0, regWdata = '0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regRdata;
  logic        irqReq;

  int applied = 0, miscompares = 0;

  // Reference model state
  logic [31:0] mAddr [16];
  logic [7:0]  mCtrl [16];
  logic [31:0] mDef;
  int          mLvl;
  int          mPrev [17];
  byte         idTab [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #4 clk = ~clk;

  vector_nest_unit u_dut (
    .clk(clk), .rst_n(rst_n), .rawIrq(rawIrq), .maskedIrq(maskedIrq),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq)
  );

  function automatic logic [31:0] maskOf(int lvl);
    logic [31:0] m = '0;
    if (lvl >= 17) return '1;
    for (int s = 0; s < lvl && s < 16; s++)
      if (mCtrl[s][5]) m[mCtrl[s][4:0]] = 1'b1;
    return m;
  endfunction

  function automatic int findLvl(logic [31:0] raw);
    for (int i = 0; i < mLvl; i++)
      if ((raw & maskOf(i + 1)) != 0) return i;
    return mLvl;
  endfunction

  function automatic logic [31:0] expRd(logic [11:0] a, logic [31:0] raw);
    int lv;
    if (a[1:0] != 0) return '0;
    if (a >= 12'h100 && a < 12'h140) return mAddr[(a - 12'h100) >> 2];
    if (a >= 12'h200 && a < 12'h240) return {24'h0, mCtrl[(a - 12'h200) >> 2]};
    if (a >= 12'hFE0) return {24'h0, idTab[(a - 12'hFE0) >> 2]};
    if (a == 12'h034) return mDef;
    if (a == 12'h030) begin
      lv = findLvl(raw);
      return (lv >= 16) ? mDef : mAddr[lv];
    end
    return '0;
  endfunction

  task automatic modelReset();
    for (int s = 0; s < 16; s++) begin mAddr[s] = '0; mCtrl[s] = '0; end
    for (int s = 0; s < 17; s++) mPrev[s] = 17;
    mDef = '0;
    mLvl = 17;
  endtask

  task automatic step(bit v, bit w, logic [11:0] a, logic [31:0] d,
                      logic [31:0] raw, logic [31:0] msk, string tag);
    logic [31:0] eRd;
    logic        eIrq;
    int          lv;
    @(negedge clk);
    regValid = v; regWrite = w; regAddr = a; regWdata = d;
    rawIrq = raw; maskedIrq = msk;
    #2;
    eRd  = expRd(a, raw);
    eIrq = |(msk & maskOf(mLvl));
    applied += 2;
    if (irqReq !== eIrq) begin
      miscompares++;
      $display("FAIL %s irqReq got %0b exp %0b (addr %h)", tag, irqReq, eIrq, a);
    end
    if (regRdata !== eRd) begin
      miscompares++;
      $display("FAIL %s regRdata got %h exp %h (addr %h)", tag, regRdata, eRd, a);
    end
    @(posedge clk);
    if (v && w) begin
      if (a >= 12'h100 && a < 12'h140 && a[1:0] == 0) mAddr[(a - 12'h100) >> 2] = d;
      else if (a >= 12'h200 && a < 12'h240 && a[1:0] == 0) mCtrl[(a - 12'h200) >> 2] = d[7:0];
      else if (a == 12'h034) mDef = d;
      else if (a == 12'h030 && mLvl < 17) mLvl = mPrev[mLvl];
    end else if (v && a == 12'h030) begin
      lv = findLvl(raw);
      if (lv < mLvl) begin mPrev[lv] = mLvl; mLvl = lv; end
    end
  endtask

  task automatic idle(logic [31:0] raw, string tag);
    step(0, 0, 12'h030, 32'h0, raw, raw, tag);
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: reset state
    step(0, 0, 12'h100, 0, 0, 0, "R8 slot addr");
    step(0, 0, 12'h23C, 0, 0, 0, "R8 slot ctrl");
    step(0, 0, 12'h034, 0, 0, 0, "R8 default");
    step(0, 0, 12'h000, 0, 32'h1, 32'h1, "R8 idle level irq");
    // R7: identification words
    for (int k = 0; k < 8; k++) step(0, 0, 12'hFE0 + 12'(4 * k), 0, 0, 0, "R7 id");
    // R12: undecoded reads
    step(0, 0, 12'h040, 0, 0, 0, "R12 hole");
    step(0, 0, 12'h102, 0, 0, 0, "R12 misaligned");
    step(0, 0, 12'h140, 0, 0, 0, "R12 past slots");

    // R1: program and read back
    for (int s = 0; s < 16; s++)
      step(1, 1, 12'h100 + 12'(4 * s), 32'h8000_0000 + 32'(s * 256), 0, 0, "R1 wr addr");
    step(1, 1, 12'h200, 32'h23, 0, 0, "R1 wr ctrl0");
    step(1, 1, 12'h208, 32'h27, 0, 0, "R1 wr ctrl2");
    step(1, 1, 12'h214, 32'h29, 0, 0, "R1 wr ctrl5");
    step(1, 1, 12'h21C, 32'h0B, 0, 0, "R11 wr ctrl7 disabled");
    step(1, 1, 12'h034, 32'hDEF0_0000, 0, 0, "R1 wr default");
    for (int s = 0; s < 16; s++) step(0, 0, 12'h100 + 12'(4 * s), 0, 0, 0, "R1 rd addr");
    step(0, 0, 12'h208, 0, 0, 0, "R1 rd ctrl2");
    step(0, 0, 12'h034, 0, 0, 0, "R1 rd default");

    // R3/R6: nesting with sources 7 then 3
    idle(32'h80, "R2 idle level");
    step(1, 0, 12'h030, 0, 32'h80, 32'h80, "R3 ack slot2");
    idle(32'h80, "R2 masked at level2");
    idle(32'h88, "R2 higher source");
    step(1, 0, 12'h030, 0, 32'h88, 32'h88, "R3 ack slot0");
    idle(32'h88, "R2 level0 quiet");
    // R4: lower pending cannot claim
    step(1, 0, 12'h030, 0, 32'h200, 32'h200, "R4 no claim at level0");
    step(1, 1, 12'h030, 32'hFFFF_FFFF, 32'h80, 32'h80, "R5 end to level2");
    step(1, 0, 12'h030, 0, 32'h200, 32'h200, "R4 no claim at level2");
    idle(32'h8, "R6 level2 after unwind");
    step(1, 1, 12'h030, 32'h0, 0, 0, "R6 end to idle");
    idle(32'h200, "R6 back at idle");

    // R11: unvectored and disabled-slot sources claim level 16
    step(1, 0, 12'h030, 0, 32'h0010_0000, 32'h0010_0000, "R11 ack unvectored");
    idle(32'h0010_0000, "R2 level16 excludes unvectored");
    idle(32'h0010_0200, "R2 level16 sees slot5");
    step(1, 0, 12'h030, 0, 32'h200, 32'h200, "R3 ack slot5 from 16");
    step(1, 1, 12'h030, 0, 0, 0, "R6 end to 16");
    step(1, 1, 12'h030, 0, 0, 0, "R6 end to idle");
    step(1, 0, 12'h030, 0, 32'h800, 32'h800, "R11 disabled source");
    idle(32'h800, "R11 level16 excludes disabled");
    // R10: enabling slot7 takes effect next cycle
    step(1, 1, 12'h21C, 32'h2B, 32'h800, 32'h800, "R10 write ctrl7");
    idle(32'h800, "R10 mask updated");
    step(1, 0, 12'h030, 0, 32'h800, 32'h800, "R10 ack slot7");
    step(1, 1, 12'h030, 0, 0, 0, "R6 end to 16");
    step(1, 1, 12'h030, 0, 0, 0, "R6 end to idle");

    // R4/R5 at idle
    step(1, 0, 12'h030, 0, 0, 0, "R4 empty ack");
    step(1, 1, 12'h030, 32'h1234, 0, 32'h1, "R5 end at idle");
    idle(32'h1, "R5 still idle");

    // R9: unqualified reads leave the level alone
    step(0, 0, 12'h030, 0, 32'h8, 32'h8, "R9 unqualified read");
    step(0, 0, 12'h030, 0, 32'h8, 32'h8, "R9 unqualified read");
    idle(32'h80, "R9 still idle");
    step(0, 1, 12'h030, 0, 32'h80, 32'h80, "R9 unqualified write");

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule